// File: doc/BRIEF.md
# Inter-Processor Doorbell Hub

The hub lets a group of processors interrupt one another and pass a data word along with each interrupt. Every processor has its own register port on the shared hub and its own interrupt output. All processors wire that output to the same interrupt number. A processor first selects a target processor, then writes a data word. That write delivers the word, together with the sender's index, into the target's one-entry mailbox and raises the target's interrupt. A typical use is a request to reschedule.

The receiving processor reads the word and the sender index from its own port. It then writes its acknowledge register, which empties the mailbox and drops its interrupt. A mailbox holds one message at a time. A send to a mailbox that is still pending is refused, and the sender learns this from its status register. If several processors send to the same free mailbox in one cycle, the lowest port index wins and the others see the refusal. A send to the sender's own index, or to an index at or beyond the processor count, is rejected with an error flag.

Each port is a plain register strobe interface. A selected cycle with `we` high is a write. A selected cycle with `we` low is a read, whose data is presented on `p_rdata` from the next clock edge and held until the next read. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `xdb_mailbox_hub`

## Requirements
- R1: After reset every interrupt output is low, every mailbox is empty, and every status word reads 0.
- R2: A write to offset 1 on port i is a send. If the stored target index t is valid and mailbox t is empty, the write stores the data word and sender index i into mailbox t, and `irq[t]` is high from the next clock edge.
- R3: Read data is presented one cycle after the read strobe. Offset 0 returns the stored target index, held in write-data bits [TID_W-1:0] with TID_W = clog2(N_PORTS)+1. Offset 2 returns the mailbox data word. Offset 3 returns the sender index of the last stored message. Offsets 5 to 7 return 0.
- R4: `irq[t]` stays high while mailbox t is pending. Any write to offset 4 on port t empties the mailbox, and the interrupt is low from the next edge. An acknowledge of an empty mailbox changes nothing.
- R5: A send to a pending mailbox is refused. The mailbox keeps its data and sender, and the sender's status busy bit (bit 1) is set.
- R6: When several ports send to the same empty mailbox in one cycle, the lowest-numbered port is accepted. Every other port in that group gets the busy bit.
- R7: A send whose target equals the sender's own index, or is N_PORTS or above, changes no mailbox and sets the sender's error bit (bit 2).
- R8: The status word at offset 4 reads as follows. Bit 0 is the port's own mailbox pending flag. Bits 1, 2 and 3 are the busy, error and accepted outcome of that port's most recent send, and each send replaces all three.
- R9: The pending check uses the state before the clock edge. A send that meets an acknowledge of the full target mailbox in the same cycle is therefore refused with busy, and the mailbox ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_sel | input | N_PORTS | Per-port access strobe |
| p_we | input | N_PORTS | Per-port write enable (1 write, 0 read) |
| p_addr | input | 3*N_PORTS | Per-port register offset, port i at bits [3i+2:3i] |
| p_wdata | input | DATA_W*N_PORTS | Per-port write data, port i at slice i |
| p_rdata | output | DATA_W*N_PORTS | Per-port registered read data, port i at slice i |
| irq | output | N_PORTS | Per-processor interrupt, high while its mailbox is pending |

## Verification
Every send or acknowledge takes effect at the clock edge that samples it. The interrupt and the status outcome bits are therefore due one edge later. Read data is registered, so it is due one edge after the read strobe and reflects the state before that edge. The bench drives each access at a falling edge, advances the reference model as of the next rising edge, and compares the interrupt lines and any read data at the following falling edge. Every result is thus judged exactly one cycle after its stimulus, against values the model computed before that edge.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_TARGET = 3'd0,
    OFS_SEND   = 3'd1,
    OFS_RXDATA = 3'd2,
    OFS_RXSRC  = 3'd3,
    OFS_STATUS = 3'd4
  } reg_ofs_e;

  // Outcome of the latest send; packed so that it lands on status bits 3..1
  typedef struct packed {
    logic done;
    logic error;
    logic busy;
  } send_result_t;
endpackage

// File: rtl/xdb_prio_arb.sv
module xdb_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic         enable,
  output logic [N-1:0] grant
);
  // Lowest index wins: the descending loop leaves the smallest set index last
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (enable && req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xdb_slot.sv
module xdb_slot #(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [SRC_W-1:0]  load_src,
  input  logic              clear,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic [SRC_W-1:0]  src
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      src  <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
      src  <= load_src;
    end else if (clear) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/xdb_port.sv
module xdb_port
  import xdb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int PORT_ID = 0,
  parameter int TID_W   = 3,
  parameter int SRC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [TID_W-1:0]  tgt_wval,
  input  logic              rx_pending,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [SRC_W-1:0]  rx_src,
  input  logic              granted,
  output logic              send_req,
  output logic [TID_W-1:0]  send_tgt,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  logic [TID_W-1:0]  tgt_q;
  send_result_t      res_q;
  logic              wr_tgt, wr_send, rd;
  logic              bad_tgt;
  logic [DATA_W-1:0] rd_mux;

  assign wr_tgt  = sel && we && (addr == OFS_TARGET);
  assign wr_send = sel && we && (addr == OFS_SEND);
  assign ack     = sel && we && (addr == OFS_STATUS);
  assign rd      = sel && !we;

  assign bad_tgt  = (tgt_q >= TID_W'(N_PORTS)) || (tgt_q == TID_W'(PORT_ID));
  assign send_req = wr_send && !bad_tgt;
  assign send_tgt = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      res_q <= '0;
    end else begin
      if (wr_tgt) tgt_q <= tgt_wval;
      if (wr_send) begin
        res_q.done  <= granted;
        res_q.error <= bad_tgt;
        res_q.busy  <= !bad_tgt && !granted;
      end
    end
  end

  always_comb begin
    case (addr)
      OFS_TARGET: rd_mux = DATA_W'(tgt_q);
      OFS_RXDATA: rd_mux = rx_data;
      OFS_RXSRC:  rd_mux = DATA_W'(rx_src);
      OFS_STATUS: rd_mux = DATA_W'({res_q, rx_pending});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/xdb_mailbox_hub.sv
module xdb_mailbox_hub
  import xdb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         p_sel,
  input  logic [N_PORTS-1:0]         p_we,
  input  logic [N_PORTS*REG_AW-1:0]  p_addr,
  input  logic [N_PORTS*DATA_W-1:0]  p_wdata,
  output logic [N_PORTS*DATA_W-1:0]  p_rdata,
  output logic [N_PORTS-1:0]         irq
);
  localparam int SRC_W = $clog2(N_PORTS);
  localparam int TID_W = SRC_W + 1;

  logic [N_PORTS-1:0]         send_req;
  logic [TID_W-1:0]           send_tgt [N_PORTS];
  logic [N_PORTS-1:0]         ack;
  logic [N_PORTS-1:0]         granted;
  logic [N_PORTS-1:0]         box_full;
  logic [DATA_W-1:0]          box_data [N_PORTS];
  logic [SRC_W-1:0]           box_src  [N_PORTS];
  logic [N_PORTS*N_PORTS-1:0] grant_flat;
  logic [N_PORTS*DATA_W-1:0]  box_data_flat;

  // One register port per processor
  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    xdb_port #(
      .N_PORTS(N_PORTS), .DATA_W(DATA_W), .PORT_ID(i),
      .TID_W(TID_W), .SRC_W(SRC_W)
    ) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (p_sel[i]),
      .we        (p_we[i]),
      .addr      (p_addr[i*REG_AW +: REG_AW]),
      .tgt_wval  (p_wdata[i*DATA_W +: TID_W]),
      .rx_pending(box_full[i]),
      .rx_data   (box_data[i]),
      .rx_src    (box_src[i]),
      .granted   (granted[i]),
      .send_req  (send_req[i]),
      .send_tgt  (send_tgt[i]),
      .ack       (ack[i]),
      .rdata     (p_rdata[i*DATA_W +: DATA_W])
    );
  end

  // One arbiter and one mailbox per target processor
  for (genvar j = 0; j < N_PORTS; j++) begin : g_tgt
    logic [N_PORTS-1:0] req, grant;
    logic [DATA_W-1:0]  ld_data;
    logic [SRC_W-1:0]   ld_src;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_req
      assign req[i] = send_req[i] && (send_tgt[i] == TID_W'(j));
    end

    xdb_prio_arb #(.N(N_PORTS)) arb_i (
      .req   (req),
      .enable(!box_full[j]),
      .grant (grant)
    );

    always_comb begin
      ld_data = '0;
      ld_src  = '0;
      for (int i = 0; i < N_PORTS; i++) begin
        if (grant[i]) begin
          ld_data = ld_data | p_wdata[i*DATA_W +: DATA_W];
          ld_src  = ld_src | SRC_W'(i);
        end
      end
    end

    xdb_slot #(.DATA_W(DATA_W), .SRC_W(SRC_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (|grant),
      .load_data(ld_data),
      .load_src (ld_src),
      .clear    (ack[j]),
      .full     (box_full[j]),
      .data     (box_data[j]),
      .src      (box_src[j])
    );

    assign grant_flat[j*N_PORTS +: N_PORTS]  = grant;
    assign box_data_flat[j*DATA_W +: DATA_W] = box_data[j];
  end

  always_comb begin
    granted = '0;
    for (int j = 0; j < N_PORTS; j++)
      for (int i = 0; i < N_PORTS; i++)
        granted[i] = granted[i] | grant_flat[j*N_PORTS + i];
  end

  assign irq = box_full;
endmodule

// File: rtl/xdb_mailbox_hub_chk.sv
module xdb_mailbox_hub_chk
  import xdb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_PORTS-1:0]         p_sel,
  input logic [N_PORTS-1:0]         p_we,
  input logic [N_PORTS*REG_AW-1:0]  p_addr,
  input logic [N_PORTS-1:0]         irq,
  input logic [N_PORTS*N_PORTS-1:0] grant_flat,
  input logic [N_PORTS*DATA_W-1:0]  box_data_flat
);
  // R1: interrupts are held low throughout reset
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq == '0);

  for (genvar j = 0; j < N_PORTS; j++) begin : g_chk
    logic ackj;
    assign ackj = p_sel[j] && p_we[j] && (p_addr[j*REG_AW +: REG_AW] == OFS_STATUS);

    // R2: an interrupt only rises when a send is granted to that target
    p_rise_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[j] && grant_flat[j*N_PORTS +: N_PORTS] == '0) |=> !irq[j]);

    // R4: acknowledge drops a pending interrupt on the next edge
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ackj && irq[j]) |=> !irq[j]);

    // R4: without acknowledge a pending interrupt stays high
    p_pending_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[j] && !ackj) |=> irq[j]);

    // R5: a pending mailbox keeps its data word
    p_pending_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[j] && !ackj) |=> $stable(box_data_flat[j*DATA_W +: DATA_W]));

    // R5: nothing is granted into a full mailbox
    p_no_grant_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[j] |-> grant_flat[j*N_PORTS +: N_PORTS] == '0);

    // R6: at most one sender accepted per target per cycle
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_flat[j*N_PORTS +: N_PORTS]));

    // R7: a processor is never granted its own mailbox
    p_no_self_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_flat[j*N_PORTS + j]);
  end
endmodule

bind xdb_mailbox_hub xdb_mailbox_hub_chk #(
  .N_PORTS(N_PORTS), .DATA_W(DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .p_sel        (p_sel),
  .p_we         (p_we),
  .p_addr       (p_addr),
  .irq          (irq),
  .grant_flat   (grant_flat),
  .box_data_flat(box_data_flat)
);

// File: tb/xdb_mailbox_hub_tb_top.sv
module xdb_mailbox_hub_tb_top;
  localparam int N  = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    p_sel = '0, p_we = '0;
  logic [3*N-1:0]  p_addr = '0;
  logic [DW*N-1:0] p_wdata = '0;
  logic [DW*N-1:0] p_rdata;
  logic [N-1:0]    irq;

  always #2 clk = ~clk;  // 250 MHz

  xdb_mailbox_hub #(.N_PORTS(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .p_sel(p_sel), .p_we(p_we),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag_o = "";

  // pending commands
  bit c_sel[N], c_we[N];
  int c_addr[N];
  logic [DW-1:0] c_wd[N];

  // reference model
  bit m_full[N];
  logic [DW-1:0] m_data[N];
  int m_src[N], m_tgt[N];
  logic [3:0] m_res[N];  // bits 3..1 = accepted, error, busy

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(int p, bit we, int a, logic [DW-1:0] d);
    c_sel[p] = 1'b1; c_we[p] = we; c_addr[p] = a; c_wd[p] = d;
  endtask

  function automatic logic [DW-1:0] status_of(int i);
    return DW'({m_res[i][3:1], m_full[i]});
  endfunction

  task automatic cycle();
    bit rd_v[N];
    logic [DW-1:0] rd_e[N];
    string rd_t[N];
    bit taken[N], full_pre[N];
    for (int i = 0; i < N; i++) begin
      p_sel[i] = c_sel[i];
      p_we[i] = c_we[i];
      p_addr[3*i +: 3] = 3'(c_addr[i]);
      p_wdata[DW*i +: DW] = c_wd[i];
      full_pre[i] = m_full[i];
      taken[i] = 1'b0;
      rd_v[i] = c_sel[i] && !c_we[i];
      case (c_addr[i])
        0: rd_e[i] = DW'(m_tgt[i]);
        2: rd_e[i] = m_data[i];
        3: rd_e[i] = DW'(m_src[i]);
        4: rd_e[i] = status_of(i);
        default: rd_e[i] = '0;
      endcase
      rd_t[i] = (tag_o != "") ? tag_o : ((c_addr[i] == 4) ? "R8" : "R3");
    end
    // sends in ascending port order: lowest port wins (R6)
    for (int i = 0; i < N; i++) begin
      if (c_sel[i] && c_we[i] && c_addr[i] == 1) begin
        int t = m_tgt[i];
        if (t >= N || t == i) m_res[i] = 4'b0100;
        else if (full_pre[t] || taken[t]) m_res[i] = 4'b0010;
        else begin
          taken[t] = 1'b1; m_res[i] = 4'b1000;
          m_data[t] = c_wd[i]; m_src[t] = i;
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      bit ackj = c_sel[j] && c_we[j] && c_addr[j] == 4;
      m_full[j] = taken[j] ? 1'b1 : (m_full[j] && !ackj);
      if (c_sel[j] && c_we[j] && c_addr[j] == 0) m_tgt[j] = int'(c_wd[j][2:0]);
    end
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < N; j++)
      chk((tag_o != "") ? tag_o : "R4", DW'(irq[j]), DW'(m_full[j]));
    for (int i = 0; i < N; i++)
      if (rd_v[i]) chk(rd_t[i], p_rdata[DW*i +: DW], rd_e[i]);
    for (int i = 0; i < N; i++) begin
      c_sel[i] = 1'b0; c_we[i] = 1'b0; c_addr[i] = 0; c_wd[i] = '0;
    end
    p_sel = '0; p_we = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < N; i++) begin
      c_sel[i] = 0; c_we[i] = 0; c_addr[i] = 0; c_wd[i] = '0;
      m_full[i] = 0; m_data[i] = '0; m_src[i] = 0; m_tgt[i] = 0; m_res[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1", DW'(irq), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: status of every port reads zero after reset
    tag_o = "R1";
    for (int i = 0; i < N; i++) put(i, 0, 4, 0);
    cycle();

    // R2: port 0 sends to processor 1
    tag_o = "R2";
    put(0, 1, 0, 1); cycle();
    put(0, 1, 1, 32'hA5A5_0001); cycle();
    // R3: receiver reads data and sender, sender reads back its target
    tag_o = "R3";
    put(1, 0, 2, 0); put(0, 0, 0, 0); cycle();
    put(1, 0, 3, 0); put(2, 0, 7, 0); cycle();
    // R8: accepted bit on sender, pending bit on receiver
    tag_o = "R8";
    put(0, 0, 4, 0); put(1, 0, 4, 0); cycle();

    // R5: send to a pending mailbox is refused
    tag_o = "R5";
    put(2, 1, 0, 1); cycle();
    put(2, 1, 1, 32'h0000_0222); cycle();
    put(2, 0, 4, 0); put(1, 0, 2, 0); cycle();

    // R9: send meets acknowledge of the full mailbox in the same cycle
    tag_o = "R9";
    put(1, 1, 4, 0); put(2, 1, 1, 32'h0000_0333); cycle();
    put(2, 0, 4, 0); put(1, 0, 2, 0); cycle();

    // R6: three ports send to the empty mailbox of processor 1 together
    tag_o = "R6";
    put(3, 1, 0, 1); cycle();
    put(0, 1, 1, 32'h100); put(2, 1, 1, 32'h200); put(3, 1, 1, 32'h300); cycle();
    put(1, 0, 2, 0); put(0, 0, 4, 0); put(2, 0, 4, 0); cycle();
    put(1, 0, 3, 0); put(3, 0, 4, 0); cycle();

    // R7: self target and out-of-range target
    tag_o = "R7";
    put(3, 1, 0, 3); cycle();
    put(3, 1, 1, 32'h777); cycle();
    put(3, 0, 4, 0); cycle();
    put(3, 1, 0, 6); cycle();
    put(3, 1, 1, 32'h778); cycle();
    put(3, 0, 4, 0); put(0, 0, 4, 0); cycle();

    // R4: acknowledge, then acknowledge of an empty mailbox
    tag_o = "R4";
    put(1, 1, 4, 0); cycle();
    put(1, 1, 4, 0); cycle();
    put(1, 0, 4, 0); put(1, 0, 4, 0); cycle();

    // constrained random traffic
    tag_o = "";
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < N; p++) begin
        int r = int'($urandom % 10);
        if (r < 2)      put(p, 1, 0, DW'($urandom % 8));
        else if (r < 4) put(p, 1, 1, $urandom);
        else if (r < 6) put(p, 1, 4, $urandom);
        else if (r < 9) put(p, 0, int'($urandom % 8), 0);
      end
      cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule